// File: doc/BRIEF.md
# Match-Gated Receive Word Gate

This block sits between a serial receive engine and a receive FIFO and decides, word by word, whether a received word is written into the FIFO. A match-only enable makes the gate discard every received word until a data match has been seen. From that point on a sticky match flag is set, and every word passes regardless of the enable. Software clears the flag with a dedicated input. If match-only is still on when the flag is cleared, discarding starts again. The safe order for leaving the mode is therefore to drop the enable first and clear the flag afterwards.

The comparator that produces the match pulse is outside the block and appears as an input. The FIFO is also outside; the block only sees its full indication. The block counts the words it discards in a saturating counter. When the FIFO is full, a word that would have been stored is lost, and a sticky receive-overflow flag is raised. All outputs are registered. The effect of a received word appears on the outputs after the first rising clock edge at which that word is presented.

Top module: `rx_match_gate`

## Requirements
- R1: While reset is asserted and after its release, fifo_wr_o, match_flag_o, rx_ovf_o and drop_cnt_o are all 0.
- R2: With match_only_i low and fifo_full_i low, each cycle with rx_valid_i high gives fifo_wr_o high in the following cycle, with fifo_wdata_o equal to that rx_data_i.
- R3: With match_only_i high, match_flag_o low and match_pulse_i low, a valid word is not written (fifo_wr_o stays low), and drop_cnt_o rises by one in the following cycle.
- R4: A valid word presented together with match_pulse_i is stored even when match_only_i is high, and match_flag_o is high in the following cycle.
- R5: While match_flag_o is high, every valid word is stored whatever match_only_i is, and drop_cnt_o does not change.
- R6: match_flag_o is sticky. It sets on match_pulse_i and clears only on match_clr_i. When both inputs are high in the same cycle, the flag ends up set.
- R7: After the flag is cleared while match_only_i is still high, valid words are discarded again. If match_only_i is lowered before the flag is cleared, no word is lost.
- R8: drop_cnt_o saturates at 255. drop_cnt_clr_i sets it to 0 in the following cycle, and a clear wins over an increment in the same cycle.
- R9: With fifo_full_i high, a word that would be stored is not written and rx_ovf_o is set; rx_ovf_o then stays high until reset. Such a word does not count as discarded. A word discarded by the match gate while the FIFO is full is counted and does not raise rx_ovf_o.
- R10: A cycle with rx_valid_i low neither writes nor changes drop_cnt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received word strobe |
| rx_data_i | input | DATA_W | Received word |
| match_only_i | input | 1 | Discard words until a match is seen |
| match_pulse_i | input | 1 | Comparator reports a match on this word |
| match_clr_i | input | 1 | Software clear of the match flag |
| fifo_full_i | input | 1 | Receive FIFO cannot accept a word |
| drop_cnt_clr_i | input | 1 | Clears the discard counter |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | DATA_W | FIFO write data |
| match_flag_o | output | 1 | Sticky match flag |
| drop_cnt_o | output | CNT_W | Saturating count of discarded words |
| rx_ovf_o | output | 1 | Sticky receive overflow |

## Verification
The hardest case to reach from the ports is counter saturation while other events compete for the same cycle: a clear arriving together with a discard, and a discard arriving while the FIFO is full. The stimulus holds match-only on with the flag clear for more than 255 consecutive valid words, which pins the counter at its ceiling. It then presents the clear together with one more discard. The overflow case is ordered so that a gated discard is checked under a full FIFO before the first lost stored word sets the sticky overflow flag.

// File: rtl/rx_match_gate_pkg.sv
package rx_match_gate_pkg;

    typedef enum logic [1:0] {
        ACT_IDLE     = 2'd0,
        ACT_STORE    = 2'd1,
        ACT_DISCARD  = 2'd2,
        ACT_OVERFLOW = 2'd3
    } rx_action_e;

    // The match gate is evaluated first; the full check only applies to
    // words that the gate would keep.
    function automatic rx_action_e rmg_classify(
        input logic valid,
        input logic only,
        input logic flag,
        input logic pulse,
        input logic full
    );
        if (!valid) begin
            return ACT_IDLE;
        end
        if (only && !flag && !pulse) begin
            return ACT_DISCARD;
        end
        if (full) begin
            return ACT_OVERFLOW;
        end
        return ACT_STORE;
    endfunction

endpackage

// File: rtl/rx_match_flag_keeper.sv
module rx_match_flag_keeper (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.flag = 1'b0;
        end
        // Set is applied last so that it wins over a simultaneous clear.
        if (set_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/rx_drop_counter.sv
module rx_drop_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/rx_gate_core.sv
module rx_gate_core
    import rx_match_gate_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              only_i,
    input  logic              flag_i,
    input  logic              pulse_i,
    input  logic              full_i,
    output logic              discard_o,
    output logic              wr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              ovf_o
);
    typedef struct packed {
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              ovf;
    } gate_state_t;

    gate_state_t st_d, st_q;
    rx_action_e  action;

    always_comb begin
        action = rmg_classify(valid_i, only_i, flag_i, pulse_i, full_i);
        st_d    = st_q;
        st_d.wr = (action == ACT_STORE);
        if (action == ACT_STORE) begin
            st_d.wdata = data_i;
        end
        if (action == ACT_OVERFLOW) begin
            st_d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign discard_o = (action == ACT_DISCARD);
    assign wr_o      = st_q.wr;
    assign wdata_o   = st_q.wdata;
    assign ovf_o     = st_q.ovf;
endmodule

// File: rtl/rx_match_gate.sv
module rx_match_gate #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic              match_only_i,
    input  logic              match_pulse_i,
    input  logic              match_clr_i,
    input  logic              fifo_full_i,
    input  logic              drop_cnt_clr_i,
    output logic              fifo_wr_o,
    output logic [DATA_W-1:0] fifo_wdata_o,
    output logic              match_flag_o,
    output logic [CNT_W-1:0]  drop_cnt_o,
    output logic              rx_ovf_o
);
    logic flag_q;
    logic discard;

    rx_match_flag_keeper flag_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (match_pulse_i),
        .clr_i  (match_clr_i),
        .flag_o (flag_q)
    );

    rx_gate_core #(.DATA_W(DATA_W)) core_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .valid_i   (rx_valid_i),
        .data_i    (rx_data_i),
        .only_i    (match_only_i),
        .flag_i    (flag_q),
        .pulse_i   (match_pulse_i),
        .full_i    (fifo_full_i),
        .discard_o (discard),
        .wr_o      (fifo_wr_o),
        .wdata_o   (fifo_wdata_o),
        .ovf_o     (rx_ovf_o)
    );

    rx_drop_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .inc_i  (discard),
        .clr_i  (drop_cnt_clr_i),
        .cnt_o  (drop_cnt_o)
    );

    assign match_flag_o = flag_q;
endmodule

// File: rtl/rx_match_gate_chk.sv
module rx_match_gate_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CNT_W  = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rx_valid_i,
    input logic [DATA_W-1:0] rx_data_i,
    input logic              match_only_i,
    input logic              match_pulse_i,
    input logic              match_clr_i,
    input logic              fifo_full_i,
    input logic              drop_cnt_clr_i,
    input logic              fifo_wr_o,
    input logic [DATA_W-1:0] fifo_wdata_o,
    input logic              match_flag_o,
    input logic [CNT_W-1:0]  drop_cnt_o,
    input logic              rx_ovf_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    p_plain_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i && !match_only_i && !fifo_full_i
        |=> fifo_wr_o && (fifo_wdata_o == $past(rx_data_i)));

    p_gated_discard_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i && match_only_i && !match_flag_o && !match_pulse_i |=> !fifo_wr_o);

    p_flag_bypass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_valid_i && match_flag_o && !fifo_full_i |=> fifo_wr_o);

    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_pulse_i |=> match_flag_o);

    p_clear_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_clr_i && !match_pulse_i |=> !match_flag_o);

    p_cnt_hold_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drop_cnt_o == CNT_TOP) && !drop_cnt_clr_i |=> (drop_cnt_o == CNT_TOP));

    p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        drop_cnt_clr_i |=> (drop_cnt_o == '0));

    p_no_write_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_full_i |=> !fifo_wr_o);

    p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_ovf_o |=> rx_ovf_o);

    p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_valid_i && !drop_cnt_clr_i |=> !fifo_wr_o && $stable(drop_cnt_o));
endmodule

bind rx_match_gate rx_match_gate_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rx_valid_i     (rx_valid_i),
    .rx_data_i      (rx_data_i),
    .match_only_i   (match_only_i),
    .match_pulse_i  (match_pulse_i),
    .match_clr_i    (match_clr_i),
    .fifo_full_i    (fifo_full_i),
    .drop_cnt_clr_i (drop_cnt_clr_i),
    .fifo_wr_o      (fifo_wr_o),
    .fifo_wdata_o   (fifo_wdata_o),
    .match_flag_o   (match_flag_o),
    .drop_cnt_o     (drop_cnt_o),
    .rx_ovf_o       (rx_ovf_o)
);

// File: tb/rx_match_gate_tb_top.sv
`timescale 1ns/100ps
module rx_match_gate_tb_top;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              rx_valid_i = 1'b0;
    logic [DATA_W-1:0] rx_data_i = '0;
    logic              match_only_i = 1'b0;
    logic              match_pulse_i = 1'b0;
    logic              match_clr_i = 1'b0;
    logic              fifo_full_i = 1'b0;
    logic              drop_cnt_clr_i = 1'b0;
    logic              fifo_wr_o;
    logic [DATA_W-1:0] fifo_wdata_o;
    logic              match_flag_o;
    logic [CNT_W-1:0]  drop_cnt_o;
    logic              rx_ovf_o;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    rx_match_gate #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_ni),
        .rx_valid_i     (rx_valid_i),
        .rx_data_i      (rx_data_i),
        .match_only_i   (match_only_i),
        .match_pulse_i  (match_pulse_i),
        .match_clr_i    (match_clr_i),
        .fifo_full_i    (fifo_full_i),
        .drop_cnt_clr_i (drop_cnt_clr_i),
        .fifo_wr_o      (fifo_wr_o),
        .fifo_wdata_o   (fifo_wdata_o),
        .match_flag_o   (match_flag_o),
        .drop_cnt_o     (drop_cnt_o),
        .rx_ovf_o       (rx_ovf_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present one cycle of inputs at a falling edge; outputs are sampled at
    // the next falling edge, after the rising edge that registers them.
    task automatic step(input logic v, input logic [DATA_W-1:0] d, input logic only,
                        input logic pulse, input logic clr, input logic full,
                        input logic cclr);
        rx_valid_i = v; rx_data_i = d; match_only_i = only;
        match_pulse_i = pulse; match_clr_i = clr; fifo_full_i = full;
        drop_cnt_clr_i = cclr;
        @(negedge clk);
        rx_valid_i = 1'b0; match_pulse_i = 1'b0; match_clr_i = 1'b0;
        drop_cnt_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "wr", 32'(fifo_wr_o), 0);
        chk("R1", "flag", 32'(match_flag_o), 0);
        chk("R1", "ovf", 32'(rx_ovf_o), 0);
        chk("R1", "cnt", 32'(drop_cnt_o), 0);
    endtask

    task automatic t_plain();
        for (int i = 0; i < 4; i++) begin
            step(1, 16'hA000 + 16'(i), 0, 0, 0, 0, 0);
            chk("R2", "wr", 32'(fifo_wr_o), 1);
            chk("R2", "data", 32'(fifo_wdata_o), 32'hA000 + 32'(i));
        end
        step(0, 16'h5555, 0, 0, 0, 0, 0);
        chk("R10", "idle wr", 32'(fifo_wr_o), 0);
        chk("R10", "idle cnt", 32'(drop_cnt_o), 0);
    endtask

    task automatic t_discard();
        for (int i = 0; i < 3; i++) begin
            step(1, 16'hB000 + 16'(i), 1, 0, 0, 0, 0);
            exp_cnt++;
            chk("R3", "wr", 32'(fifo_wr_o), 0);
            chk("R3", "cnt", 32'(drop_cnt_o), 32'(exp_cnt));
        end
        step(0, 16'h0, 1, 0, 0, 0, 0);
        chk("R10", "idle cnt", 32'(drop_cnt_o), 32'(exp_cnt));
    endtask

    task automatic t_match_word();
        step(1, 16'hC0DE, 1, 1, 0, 0, 0);
        chk("R4", "wr", 32'(fifo_wr_o), 1);
        chk("R4", "data", 32'(fifo_wdata_o), 32'hC0DE);
        chk("R4", "flag", 32'(match_flag_o), 1);
    endtask

    task automatic t_after_match();
        step(1, 16'hD001, 1, 0, 0, 0, 0);
        chk("R5", "wr only=1", 32'(fifo_wr_o), 1);
        chk("R5", "data", 32'(fifo_wdata_o), 32'hD001);
        chk("R5", "cnt", 32'(drop_cnt_o), 32'(exp_cnt));
        step(1, 16'hD002, 0, 0, 0, 0, 0);
        chk("R5", "wr only=0", 32'(fifo_wr_o), 1);
    endtask

    task automatic t_sticky();
        step(0, 16'h0, 1, 0, 0, 0, 0);
        chk("R6", "flag held", 32'(match_flag_o), 1);
        step(0, 16'h0, 1, 1, 1, 0, 0);
        chk("R6", "set wins", 32'(match_flag_o), 1);
        step(0, 16'h0, 1, 0, 1, 0, 0);
        chk("R6", "cleared", 32'(match_flag_o), 0);
    endtask

    task automatic t_resume();
        step(1, 16'hE001, 1, 0, 0, 0, 0);
        exp_cnt++;
        chk("R7", "discard again", 32'(fifo_wr_o), 0);
        chk("R7", "cnt", 32'(drop_cnt_o), 32'(exp_cnt));
        step(1, 16'hE002, 1, 1, 0, 0, 0);
        chk("R7", "rematch", 32'(match_flag_o), 1);
        step(0, 16'h0, 0, 0, 0, 0, 0);
        step(0, 16'h0, 0, 0, 1, 0, 0);
        step(1, 16'hE003, 0, 0, 0, 0, 0);
        chk("R7", "safe order wr", 32'(fifo_wr_o), 1);
        chk("R7", "safe order data", 32'(fifo_wdata_o), 32'hE003);
    endtask

    task automatic t_saturate();
        step(0, 16'h0, 1, 0, 0, 0, 1);
        exp_cnt = 0;
        chk("R8", "clear", 32'(drop_cnt_o), 0);
        for (int i = 0; i < 260; i++) begin
            step(1, 16'(i), 1, 0, 0, 0, 0);
        end
        chk("R8", "saturated", 32'(drop_cnt_o), 255);
        step(1, 16'h1, 1, 0, 0, 0, 1);
        chk("R8", "clear wins", 32'(drop_cnt_o), 0);
    endtask

    task automatic t_full();
        exp_cnt = 0;
        step(1, 16'hF001, 1, 0, 0, 1, 0);
        exp_cnt++;
        chk("R9", "gated discard cnt", 32'(drop_cnt_o), 32'(exp_cnt));
        chk("R9", "gated no ovf", 32'(rx_ovf_o), 0);
        step(1, 16'hF002, 0, 0, 0, 1, 0);
        chk("R9", "no wr", 32'(fifo_wr_o), 0);
        chk("R9", "ovf set", 32'(rx_ovf_o), 1);
        chk("R9", "not counted", 32'(drop_cnt_o), 32'(exp_cnt));
        step(1, 16'hF003, 0, 0, 0, 0, 0);
        chk("R9", "ovf sticky", 32'(rx_ovf_o), 1);
        chk("R9", "wr resumes", 32'(fifo_wr_o), 1);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_discard();
        t_match_word();
        t_after_match();
        t_sticky();
        t_resume();
        t_saturate();
        t_full();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule